// File: doc/BRIEF.md
# Bus Master Hold Gate

This block sits on the merged request stream from the chip's bus masters, just below the port that leads to the upstream memory controller. During the entry into a deep processor sleep state, it holds back every non-isochronous request. The window opens in the same cycle that the "enter deep sleep" message leaves for the controller. It closes when the controller's "return to shallow sleep" acknowledge comes back. Isochronous requests are never held. They go straight to the upstream port in every state.

A non-isochronous request that arrives while the window is open is not refused. It goes into a small hold queue. After the window closes, the queue drains upstream one entry per cycle, in arrival order, under valid/ready flow control. A new non-isochronous request that arrives while entries are still waiting is appended behind them, so it cannot overtake them. When the queue is full, the requester sees ready low.

The block also holds an 8-bit register whose bit 0 is an arbiter-disable flag. Software may write and read this bit. It has no effect on the gating.

A controller state machine has three states:
- `ST_OPEN`: no window is open and the queue is empty.
- `ST_HOLD`: the window is open.
- `ST_DRAIN`: the window is closed and queued entries remain.

Its transitions are:
- `OPEN->HOLD` on the sleep-entry message.
- `HOLD->HOLD` when the sleep-entry message is sent again, even if an acknowledge arrives in the same cycle.
- `HOLD->DRAIN` on the acknowledge when the queue holds entries or is taking one that cycle.
- `HOLD->OPEN` on the acknowledge when the queue is empty and takes nothing that cycle.
- `DRAIN->HOLD` on a new sleep-entry message.
- `DRAIN->OPEN` when the last entry leaves and none arrives in the same cycle.

Top module: `bmg_hold_gate`

## Requirements
- R1: After reset, the register reads 00h, `block_o` is 0, `up_valid_o` is 0 and the hold queue is empty.
- R2: A write to the register stores `cfg_wdata_i[0]` in bit 0, and it reads back from the next cycle on. Bits 7:1 always read 0.
- R3: The arbiter-disable bit has no effect on gating. With bit 0 set and no window open, a non-isochronous request appears on the upstream port in the same cycle.
- R4: Blocking starts in the same cycle that `sleep_go_i` is high. In that cycle `block_o` is 1, and a non-isochronous request in that cycle is accepted into the queue and not forwarded.
- R5: An isochronous request (`req_isoch_i`=1) is forwarded upstream in the same cycle, in every state, with its data and with `up_isoch_o`=1. Its ready equals `up_ready_i`.
- R6: While the window is open, no non-isochronous transfer leaves upstream. Each accepted non-isochronous request is later delivered exactly once, so none is lost.
- R7: After the window closes, queued entries leave starting in the cycle after the acknowledge. They leave one per cycle, in arrival order. An entry that is not taken stays on `up_data_o` unchanged.
- R8: A non-isochronous request that arrives while queued entries remain goes out after all of those entries.
- R9: When the queue holds HOLD_DEPTH entries and a non-isochronous request must be queued, `req_ready_o` is 0.
- R10: An acknowledge that arrives while no window is open is ignored. `block_o` stays 0 and non-isochronous requests keep passing directly.
- R11: `block_o` stays 1 through the cycle in which the acknowledge is received. It falls in the next cycle, unless a new sleep-entry message is sent in that cycle.
- R12: While the queue drains, an isochronous request takes the upstream port ahead of the queue head, and the head waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_go_i | input | 1 | Sleep-entry message sent upstream this cycle |
| wake_ack_i | input | 1 | Return-to-shallow-sleep acknowledge received this cycle |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | 8 | Register write data |
| cfg_rdata_o | output | 8 | Register read data (bit 0 arbiter-disable) |
| req_valid_i | input | 1 | Master request valid |
| req_isoch_i | input | 1 | Request is isochronous |
| req_data_i | input | DATA_W | Request payload |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| up_valid_o | output | 1 | Upstream transfer valid |
| up_isoch_o | output | 1 | Upstream transfer is isochronous |
| up_data_o | output | DATA_W | Upstream payload |
| up_ready_i | input | 1 | Upstream accepts the transfer |
| block_o | output | 1 | Blocking window active |

## Verification
The bench builds the block with DATA_W=32 and HOLD_DEPTH=4. With a queue that shallow, a short burst inside one window fills it, so full-queue stalls, refill while draining, and re-entry into a window with entries still pending all occur often in the random phase. The 32-bit payload lets each transfer carry a distinct tag. That makes reordering and loss visible to the order scoreboard.

// File: rtl/bmg_pkg.sv
package bmg_pkg;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRAIN = 2'd2
    } gate_state_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ISO    = 2'd1,
        SRC_QUEUE  = 2'd2,
        SRC_DIRECT = 2'd3
    } up_src_e;

endpackage

// File: rtl/bmg_hold_fifo.sv
module bmg_hold_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [DW-1:0]                 head_data,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          empty,
    output logic                          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_data = store[rd_ptr];
    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));

endmodule

// File: rtl/bmg_ctrl_fsm.sv
module bmg_ctrl_fsm
    import bmg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sleep_go,
    input  logic        wake_ack,
    input  logic        q_empty,
    input  logic        q_last,
    input  logic        q_push,
    input  logic        q_pop,
    output gate_state_e state,
    output logic        blocking,
    output logic        queued_path
);
    gate_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OPEN;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: begin
                if (sleep_go) state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (sleep_go) begin
                    state_nx = ST_HOLD;
                end else if (wake_ack) begin
                    state_nx = (q_empty && !q_push) ? ST_OPEN : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (sleep_go) begin
                    state_nx = ST_HOLD;
                end else if (q_empty || (q_pop && q_last && !q_push)) begin
                    state_nx = ST_OPEN;
                end
            end
            default: state_nx = ST_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        blocking    = 1'b0;
        queued_path = 1'b0;
        unique case (state)
            ST_OPEN: begin
                blocking    = sleep_go;
                queued_path = sleep_go;
            end
            ST_HOLD: begin
                blocking    = 1'b1;
                queued_path = 1'b1;
            end
            ST_DRAIN: begin
                blocking    = sleep_go;
                queued_path = 1'b1;
            end
            default: begin
                blocking    = 1'b0;
                queued_path = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bmg_arb_scratch.sv
module bmg_arb_scratch #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata
);
    logic arb_off_q;
    logic unused_upper;

    assign unused_upper = ^wdata[REG_W-1:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_off_q <= 1'b0;
        end else if (we) begin
            arb_off_q <= wdata[0];
        end
    end

    assign rdata = {{(REG_W-1){1'b0}}, arb_off_q};

endmodule

// File: rtl/bmg_hold_gate.sv
module bmg_hold_gate
    import bmg_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int HOLD_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_go_i,
    input  logic              wake_ack_i,
    input  logic              cfg_we_i,
    input  logic [7:0]        cfg_wdata_i,
    output logic [7:0]        cfg_rdata_o,
    input  logic              req_valid_i,
    input  logic              req_isoch_i,
    input  logic [DATA_W-1:0] req_data_i,
    output logic              req_ready_o,
    output logic              up_valid_o,
    output logic              up_isoch_o,
    output logic [DATA_W-1:0] up_data_o,
    input  logic              up_ready_i,
    output logic              block_o
);
    localparam int CW = $clog2(HOLD_DEPTH+1);

    gate_state_e       st;
    up_src_e           src;
    logic              blocking, queued_path;
    logic              iso_req, nis_req;
    logic              q_push, q_pop, q_empty, q_full, q_last;
    logic [CW-1:0]     q_count;
    logic [DATA_W-1:0] q_head;

    assign iso_req = req_valid_i && req_isoch_i;
    assign nis_req = req_valid_i && !req_isoch_i;

    bmg_arb_scratch #(.REG_W(8)) u_scratch (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we_i),
        .wdata (cfg_wdata_i),
        .rdata (cfg_rdata_o)
    );

    bmg_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_go    (sleep_go_i),
        .wake_ack    (wake_ack_i),
        .q_empty     (q_empty),
        .q_last      (q_last),
        .q_push      (q_push),
        .q_pop       (q_pop),
        .state       (st),
        .blocking    (blocking),
        .queued_path (queued_path)
    );

    bmg_hold_fifo #(.DW(DATA_W), .DEPTH(HOLD_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (req_data_i),
        .pop       (q_pop),
        .head_data (q_head),
        .count     (q_count),
        .empty     (q_empty),
        .full      (q_full)
    );

    assign q_last = (q_count == CW'(1));

    // upstream source selection: isochronous first, then queue head, then direct
    always_comb begin
        if (iso_req) begin
            src = SRC_ISO;
        end else if (!blocking && (st == ST_DRAIN) && !q_empty) begin
            src = SRC_QUEUE;
        end else if (nis_req && !queued_path) begin
            src = SRC_DIRECT;
        end else begin
            src = SRC_NONE;
        end
    end

    always_comb begin
        up_valid_o = 1'b0;
        up_isoch_o = 1'b0;
        up_data_o  = '0;
        unique case (src)
            SRC_ISO: begin
                up_valid_o = 1'b1;
                up_isoch_o = 1'b1;
                up_data_o  = req_data_i;
            end
            SRC_QUEUE: begin
                up_valid_o = 1'b1;
                up_data_o  = q_head;
            end
            SRC_DIRECT: begin
                up_valid_o = 1'b1;
                up_data_o  = req_data_i;
            end
            default: begin
                up_valid_o = 1'b0;
            end
        endcase
    end

    assign q_push = nis_req && queued_path && !q_full;
    assign q_pop  = (src == SRC_QUEUE) && up_ready_i;

    always_comb begin
        if (req_isoch_i) begin
            req_ready_o = up_ready_i;
        end else if (queued_path) begin
            req_ready_o = !q_full;
        end else begin
            req_ready_o = up_ready_i;
        end
    end

    assign block_o = blocking;

endmodule

// File: rtl/bmg_hold_gate_chk.sv
module bmg_hold_gate_chk #(
    parameter int DATA_W     = 32,
    parameter int HOLD_DEPTH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sleep_go_i,
    input logic                         wake_ack_i,
    input logic                         cfg_we_i,
    input logic [7:0]                   cfg_wdata_i,
    input logic [7:0]                   cfg_rdata_o,
    input logic                         req_valid_i,
    input logic                         req_isoch_i,
    input logic [DATA_W-1:0]            req_data_i,
    input logic                         req_ready_o,
    input logic                         up_valid_o,
    input logic                         up_isoch_o,
    input logic [DATA_W-1:0]            up_data_o,
    input logic                         up_ready_i,
    input logic                         block_o,
    input logic [$clog2(HOLD_DEPTH+1)-1:0] q_count,
    input logic                         draining
);
    localparam int CW = $clog2(HOLD_DEPTH+1);

    p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_rdata_o == {7'b0, $past(cfg_wdata_i[0])}));

    p_block_on_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_go_i |-> block_o);

    p_isoch_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_isoch_i) |->
            (up_valid_o && up_isoch_o && up_data_o == req_data_i && req_ready_o == up_ready_i));

    p_no_nonisoch_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (block_o && up_valid_o) |-> up_isoch_o);

    p_head_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && up_valid_o && !up_isoch_o && !up_ready_i && !sleep_go_i)
            |=> (!(up_valid_o && !up_isoch_o) || $stable(up_data_o)));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_isoch_i && (block_o || draining) && q_count == CW'(HOLD_DEPTH))
            |-> !req_ready_o);

    p_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_ack_i && !block_o) |=> (!block_o || sleep_go_i));

    p_window_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (block_o && wake_ack_i && !sleep_go_i) |=> (!block_o || sleep_go_i));

endmodule

bind bmg_hold_gate bmg_hold_gate_chk #(
    .DATA_W     (DATA_W),
    .HOLD_DEPTH (HOLD_DEPTH)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_go_i  (sleep_go_i),
    .wake_ack_i  (wake_ack_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .req_valid_i (req_valid_i),
    .req_isoch_i (req_isoch_i),
    .req_data_i  (req_data_i),
    .req_ready_o (req_ready_o),
    .up_valid_o  (up_valid_o),
    .up_isoch_o  (up_isoch_o),
    .up_data_o   (up_data_o),
    .up_ready_i  (up_ready_i),
    .block_o     (block_o),
    .q_count     (q_count),
    .draining    (st == bmg_pkg::ST_DRAIN)
);

// File: tb/bmg_hold_gate_tb_top.sv
module bmg_hold_gate_tb_top;
    localparam int DW    = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_go = 1'b0, wake_ack = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          req_valid = 1'b0, req_isoch = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready;
    logic          up_valid, up_isoch;
    logic [DW-1:0] up_data;
    logic          up_ready = 1'b0;
    logic          block;

    int n_cmp = 0;
    int n_bad = 0;
    bit exp_hold = 1'b0;
    bit done = 1'b0;
    logic [DW-1:0] exp_q [$];

    always #4 clk = ~clk;

    bmg_hold_gate #(.DATA_W(DW), .HOLD_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sleep_go_i(sleep_go), .wake_ack_i(wake_ack),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .req_valid_i(req_valid), .req_isoch_i(req_isoch), .req_data_i(req_data),
        .req_ready_o(req_ready),
        .up_valid_o(up_valid), .up_isoch_o(up_isoch), .up_data_o(up_data),
        .up_ready_i(up_ready), .block_o(block)
    );

    function automatic logic [7:0] exp_rdata(input logic [7:0] wd);
        return {7'b0, wd[0]};
    endfunction

    function automatic bit exp_block_now(input bit hold, input bit go);
        return hold || go;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard over one cycle, then advance to next negedge
    task automatic tick();
        #2;
        chk(block == exp_block_now(exp_hold, sleep_go), "R11 window", block, exp_block_now(exp_hold, sleep_go));
        if (req_valid && req_isoch && req_ready) begin
            chk(up_valid && up_isoch && up_data == req_data, "R5 isoch pass", up_data, req_data);
        end
        if (req_valid && !req_isoch && req_ready) exp_q.push_back(req_data);
        if (up_valid && up_ready && !up_isoch) begin
            chk(!exp_block_now(exp_hold, sleep_go), "R6 no release in window", 1, 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 spurious transfer", up_data, 0);
            end else begin
                chk(up_data == exp_q[0], "R7 order", up_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
        if (sleep_go) exp_hold = 1'b1;
        else if (wake_ack) exp_hold = 1'b0;
        @(negedge clk);
    endtask

    task automatic send(input bit v, input bit iso, input logic [DW-1:0] d, input bit ur);
        req_valid = v; req_isoch = iso; req_data = d; up_ready = ur;
        #1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        #1;
        chk(cfg_rdata == 8'h00, "R1 reg reset", cfg_rdata, 0);
        chk(block == 1'b0, "R1 block reset", block, 0);
        chk(up_valid == 1'b0, "R1 up idle", up_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2
        cfg_we = 1'b1; cfg_wdata = 8'hFF; tick();
        cfg_we = 1'b0; #1;
        chk(cfg_rdata == exp_rdata(8'hFF), "R2 write FF", cfg_rdata, exp_rdata(8'hFF));
        cfg_we = 1'b1; cfg_wdata = 8'hFE; tick();
        cfg_we = 1'b0; #1;
        chk(cfg_rdata == exp_rdata(8'hFE), "R2 write FE", cfg_rdata, exp_rdata(8'hFE));
        cfg_we = 1'b1; cfg_wdata = 8'h01; tick();
        cfg_we = 1'b0;

        // R3 scratch bit set, request passes directly
        send(1, 0, 32'hA1, 1);
        chk(up_valid && !up_isoch && up_data == 32'hA1, "R3 direct pass", up_data, 32'hA1);
        tick();

        // R4 window opens with the message
        sleep_go = 1'b1;
        send(1, 0, 32'hA2, 1);
        chk(block == 1'b1, "R4 block same cycle", block, 1);
        chk(up_valid == 1'b0 && req_ready == 1'b1, "R4 queued not forwarded", {up_valid, req_ready}, 2'b01);
        tick();
        sleep_go = 1'b0;

        // R6 held
        send(1, 0, 32'hA3, 1);
        chk(up_valid == 1'b0 && req_ready == 1'b1, "R6 held", {up_valid, req_ready}, 2'b01);
        tick();
        send(1, 0, 32'hA4, 1); tick();

        // R5 isoch passes inside window
        send(1, 1, 32'hC1, 1);
        chk(up_valid && up_isoch && up_data == 32'hC1 && req_ready, "R5 isoch in window", up_data, 32'hC1);
        tick();

        // R9 fill then stall
        send(1, 0, 32'hA5, 1); tick();
        send(1, 0, 32'hA6, 1);
        chk(req_ready == 1'b0, "R9 full stall", req_ready, 0);
        tick();

        // R11 ack
        send(0, 0, 0, 0);
        wake_ack = 1'b1; #1;
        chk(block == 1'b1, "R11 block in ack cycle", block, 1);
        chk(up_valid == 1'b0, "R7 no release in ack cycle", up_valid, 0);
        tick();
        wake_ack = 1'b0; #1;
        chk(block == 1'b0, "R11 block drops", block, 0);

        // R7 release in order with backpressure
        send(0, 0, 0, 1);
        chk(up_valid && up_data == 32'hA2, "R7 first out", up_data, 32'hA2);
        tick();
        send(0, 0, 0, 0);
        chk(up_valid && up_data == 32'hA3, "R7 next head", up_data, 32'hA3);
        tick();
        #1;
        chk(up_valid && up_data == 32'hA3, "R7 head held", up_data, 32'hA3);

        // R12 isoch ahead of queue
        send(1, 1, 32'hC2, 1);
        chk(up_isoch && up_data == 32'hC2, "R12 isoch priority", up_data, 32'hC2);
        tick();

        // R8 new non-isoch goes behind queue
        send(1, 0, 32'hA7, 1);
        chk(up_data == 32'hA3 && req_ready, "R8 queue first", up_data, 32'hA3);
        tick();
        send(0, 0, 0, 1); tick();
        tick();
        #1;
        chk(up_valid && up_data == 32'hA7, "R8 new last", up_data, 32'hA7);
        tick();
        #1;
        chk(up_valid == 1'b0, "R7 queue drained", up_valid, 0);

        // R10 stray ack
        wake_ack = 1'b1; tick();
        wake_ack = 1'b0; #1;
        chk(block == 1'b0, "R10 stray ack ignored", block, 0);
        send(1, 0, 32'hA8, 1);
        chk(up_valid && up_data == 32'hA8, "R10 direct after stray ack", up_data, 32'hA8);
        tick();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            req_valid = ($urandom % 100) < 60;
            req_isoch = ($urandom % 100) < 25;
            req_data  = $urandom;
            up_ready  = ($urandom % 100) < 70;
            sleep_go  = !exp_hold && (($urandom % 40) == 0);
            wake_ack  = exp_hold ? (($urandom % 15) == 0) : (($urandom % 50) == 0);
            tick();
        end

        // flush
        sleep_go = 1'b0; req_valid = 1'b0;
        wake_ack = exp_hold; tick();
        wake_ack = 1'b0; up_ready = 1'b1;
        for (int i = 0; i < DEPTH + 4; i++) tick();
        chk(exp_q.size() == 0, "R6 nothing lost", exp_q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule